// File: doc/BRIEF.md
# Binary Hit Pipeline with Triggered Event Buffer

This block takes one binary comparator bit per channel on every bunch-crossing clock and passes it through a hit detector. The detector can either follow the comparator level or fire a single-cycle pulse when the comparator turns on. Each detector result is written into a 256-entry circular latency pipeline. When a level-1 trigger arrives, the block reads the entry written a programmed number of clocks earlier and stores it, with its pipeline address and a latency-error flag, in an event buffer that holds up to 32 events.

A serialiser empties the buffer in trigger order. Each event goes out on one line, one bit per clock, as an unsparsified frame: two start bits, two error bits, the 8-bit pipeline address, and then every channel bit. When more events are waiting, frames follow each other with no idle gap. A synchronous fast reset clears the pipeline pointers, the buffer and any pending error, and stops a frame that is being sent.

Top module: `hp_trig_readout`

## Requirements
- R1: With `det_mode_i`=0 (level mode), the detector result for a channel equals that channel's comparator bit.
- R2: With `det_mode_i`=1 (edge mode), the detector result is 1 only when the comparator is 1 now and was 0 at the previous clock. A comparator held high gives one result of 1, followed by 0s.
- R3: The detector result is written into the pipeline one clock after the comparator is sampled. A trigger sampled at edge E captures the entry that was written at edge E-`lat_i`, for `lat_i` from 1 to 255.
- R4: A frame is 12+N_CH bits long, sent one bit per clock. In order, the bits are: 1, 1, overflow bit, latency-error bit, the address with MSB first, and then channel 0 to channel N_CH-1. The line is 0 when no frame is being sent.
- R5: The write pointer is 0 at the first edge after reset or fast reset and increments by one every clock. The frame's address field is (write pointer − `lat_i`) mod 256, taken at the trigger edge.
- R6: The buffer holds up to 32 events and `buf_full_o` is high when it holds 32. A trigger is dropped when `buf_full_o` is high at the trigger edge, even if an event leaves the buffer at that same edge. `buf_cnt_o` gives the number of events held.
- R7: After a trigger is dropped, the overflow bit is 1 in the first frame that starts after the drop edge. That frame clears it.
- R8: The latency-error bit is 1 when `lat_i` is 0, or when fewer than `lat_i` samples have been written since reset or fast reset. In that case, all channel bits of the frame are 0.
- R9: `fast_rst_i` has priority over a trigger at the same edge. It empties the buffer, clears the pending overflow and the write history, and forces the serial line to 0 from the next clock.
- R10: Frames leave in trigger order, one per accepted trigger. When another event is waiting, the next frame starts on the clock after the last bit of the current frame.
- R11: After `rst_ni` is asserted, `sdat_o`, `buf_full_o`, `frame_active_o` and `buf_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_rst_i | input | 1 | Synchronous fast reset of the pointers, buffer and serialiser |
| comp_i | input | N_CH | Comparator outputs, one bit per channel |
| trig_i | input | 1 | Level-1 trigger, one clock per trigger |
| det_mode_i | input | 1 | 0 = level detection, 1 = rising-edge detection |
| lat_i | input | 8 | Trigger latency in clocks |
| sdat_o | output | 1 | Serial frame output |
| buf_full_o | output | 1 | Event buffer holds 32 events |
| buf_cnt_o | output | 6 | Number of events in the buffer |
| frame_active_o | output | 1 | A frame is being sent |

## Verification
The hardest situation to reach is an overflow whose error bit has to appear on exactly one later frame, particularly when a fast reset arrives while that flag is still pending and the buffer is full. The stimulus fires trigger bursts longer than the buffer, so the buffer fills while a frame is being sent. It then issues a fast reset in the middle of a frame and checks that later frames carry no overflow bit. Directed edge-mode patterns aim the latency at the comparator's rising edge and at its held-high plateau. Early triggers, and a zero latency, exercise the latency-error path.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned HDR_W = 4;
  typedef enum logic {DET_LEVEL = 1'b0, DET_EDGE = 1'b1} det_mode_e;
endpackage

// File: rtl/hp_hit_detect.sv
module hp_hit_detect import hp_pkg::*; #(
  parameter int unsigned N_CH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] comp_i,
  input  det_mode_e       mode_i,
  output logic [N_CH-1:0] det_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic prev_q, det_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        det_q  <= 1'b0;
      end else begin
        prev_q <= comp_i[c];
        det_q  <= (mode_i == DET_EDGE) ? (comp_i[c] & ~prev_q) : comp_i[c];
      end
    end
    assign det_o[c] = det_q;
  end

  // R1
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == DET_LEVEL) |=> (det_o == $past(comp_i)));
  // R2
  edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == DET_EDGE) |=> ((det_o & $past(det_o)) == '0));
endmodule

// File: rtl/hp_lat_pipe.sv
module hp_lat_pipe #(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned FW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [N_CH-1:0] det_i,
  input  logic [AW-1:0]   lat_i,
  output logic [AW-1:0]   rd_addr_o,
  output logic [N_CH-1:0] rd_data_o,
  output logic            lat_err_o
);
  logic [AW-1:0]   wr_ptr_q;
  logic [FW-1:0]   fill_q;
  logic [N_CH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      fill_q   <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + 1'b1;
      if (fill_q != FW'(DEPTH)) fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    mem_q[wr_ptr_q] <= det_i;
  end

  // entry not yet written since clear, or latency would alias the write slot
  assign lat_err_o = (lat_i == '0) || (fill_q < FW'(lat_i));
  assign rd_addr_o = wr_ptr_q - lat_i;
  assign rd_data_o = lat_err_o ? '0 : mem_q[rd_addr_o];

  // R5
  wr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (wr_ptr_q == AW'($past(wr_ptr_q) + 1'b1)));
  // R9
  pipe_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (wr_ptr_q == '0 && fill_q == '0));
  // R8
  zero_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_i == '0) |-> lat_err_o);
endmodule

// File: rtl/hp_trig_buf.sv
module hp_trig_buf #(
  parameter int unsigned W     = 25,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
  // full is judged before any same-edge pop
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  // R6
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clr_i) |=> (cnt_o == $past(cnt_o)));
  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(DEPTH));
endmodule

// File: rtl/hp_frame_ser.sv
module hp_frame_ser import hp_pkg::*; #(
  parameter int unsigned N_CH = 16,
  parameter int unsigned AW   = 8,
  localparam int unsigned FL  = HDR_W + AW + N_CH,
  localparam int unsigned CW  = $clog2(FL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            avail_i,
  input  logic            ovf_i,
  input  logic            lat_err_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [N_CH-1:0] data_i,
  output logic            pop_o,
  output logic            sdat_o,
  output logic            active_o
);
  logic [FL-1:0] sreg_q, frame_w;
  logic [CW-1:0] cnt_q;
  logic          busy_q, last_w;

  always_comb begin
    frame_w = '0;
    frame_w[FL-1 -: 2] = 2'b11;
    frame_w[FL-3]      = ovf_i;
    frame_w[FL-4]      = lat_err_i;
    frame_w[N_CH +: AW] = addr_i;
    for (int c = 0; c < int'(N_CH); c++) frame_w[N_CH-1-c] = data_i[c];
  end

  assign last_w = busy_q && (cnt_q == '0);
  assign pop_o  = !clr_i && avail_i && (!busy_q || last_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (clr_i) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (pop_o) begin
      sreg_q <= frame_w;
      cnt_q  <= CW'(FL - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      sreg_q <= {sreg_q[FL-2:0], 1'b0};
      if (last_w) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign sdat_o   = busy_q & sreg_q[FL-1];
  assign active_o = busy_q;

  // R4
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> (sdat_o && active_o));
  // R9
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!active_o && !sdat_o));
endmodule

// File: rtl/hp_trig_readout.sv
module hp_trig_readout import hp_pkg::*; #(
  parameter int unsigned N_CH       = 16,
  parameter int unsigned PIPE_DEPTH = 256,
  parameter int unsigned BUF_DEPTH  = 32,
  localparam int unsigned AW        = $clog2(PIPE_DEPTH),
  localparam int unsigned EW        = 1 + AW + N_CH,
  localparam int unsigned CW        = $clog2(BUF_DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fast_rst_i,
  input  logic [N_CH-1:0] comp_i,
  input  logic            trig_i,
  input  logic            det_mode_i,
  input  logic [AW-1:0]   lat_i,
  output logic            sdat_o,
  output logic            buf_full_o,
  output logic [CW-1:0]   buf_cnt_o,
  output logic            frame_active_o
);
  logic [N_CH-1:0] det_w, rd_data_w;
  logic [AW-1:0]   rd_addr_w;
  logic            lat_err_w, buf_empty_w, pop_w, push_w, drop_w;
  logic [EW-1:0]   evt_in_w, evt_out_w;
  logic            ovf_q;

  hp_hit_detect #(.N_CH(N_CH)) i_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .comp_i (comp_i),
    .mode_i (det_mode_e'(det_mode_i)),
    .det_o  (det_w)
  );

  hp_lat_pipe #(.N_CH(N_CH), .DEPTH(PIPE_DEPTH)) i_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (fast_rst_i),
    .det_i     (det_w),
    .lat_i     (lat_i),
    .rd_addr_o (rd_addr_w),
    .rd_data_o (rd_data_w),
    .lat_err_o (lat_err_w)
  );

  assign push_w   = trig_i & ~fast_rst_i;
  assign drop_w   = push_w & buf_full_o;
  assign evt_in_w = {lat_err_w, rd_addr_w, rd_data_w};

  hp_trig_buf #(.W(EW), .DEPTH(BUF_DEPTH)) i_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fast_rst_i),
    .push_i  (push_w),
    .data_i  (evt_in_w),
    .pop_i   (pop_w),
    .data_o  (evt_out_w),
    .full_o  (buf_full_o),
    .empty_o (buf_empty_w),
    .cnt_o   (buf_cnt_o)
  );

  // a drop on the load edge stays pending for the following frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ovf_q <= 1'b0;
    else if (fast_rst_i) ovf_q <= 1'b0;
    else                 ovf_q <= drop_w | (ovf_q & ~pop_w);
  end

  hp_frame_ser #(.N_CH(N_CH), .AW(AW)) i_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (fast_rst_i),
    .avail_i   (~buf_empty_w),
    .ovf_i     (ovf_q),
    .lat_err_i (evt_out_w[EW-1]),
    .addr_i    (evt_out_w[N_CH +: AW]),
    .data_i    (evt_out_w[N_CH-1:0]),
    .pop_o     (pop_w),
    .sdat_o    (sdat_o),
    .active_o  (frame_active_o)
  );

  // R7
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_w |=> ovf_q);
  // R9
  fast_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_rst_i |=> (buf_cnt_o == '0 && !ovf_q));
endmodule

// File: tb/test_hp_trig_readout.sv
module test_hp_trig_readout;
  localparam int N  = 16;
  localparam int L  = 12 + N;
  localparam int HR = 1024;

  logic clk = 1'b0, rst_ni = 1'b0, fast_rst = 1'b0, trig = 1'b0, mode = 1'b0;
  logic [N-1:0] comp = '0;
  logic [7:0]   lat = 8'd1;
  logic sdat, full, act;
  logic [5:0] cnt;

  always #10 clk = ~clk;

  hp_trig_readout #(.N_CH(N), .PIPE_DEPTH(256), .BUF_DEPTH(32)) i_hp_trig_readout (
    .clk_i(clk), .rst_ni(rst_ni), .fast_rst_i(fast_rst), .comp_i(comp), .trig_i(trig),
    .det_mode_i(mode), .lat_i(lat), .sdat_o(sdat), .buf_full_o(full), .buf_cnt_o(cnt),
    .frame_active_o(act)
  );

  int checks = 0, fails = 0, edge_n = -1, base = 0;
  logic [N-1:0] det_h [HR];
  bit mode_h [HR];
  logic [N-1:0] prev_comp = '0;
  logic [8+N:0] exp_q[$];
  bit mode_q[$];
  int drop_q[$];
  bit in_frame = 0, ovf_exp = 0;
  int pos = 0, last_end = -10, btb_n = 0, accepted_n = 0, dropped_n = 0;
  logic [L-1:0] fb;

  function automatic logic [N-1:0] det_at(int k);
    if (k < 0) return '0;
    return det_h[k % HR];
  endfunction

  function automatic bit mode_at(int k);
    if (k < 0) return 1'b0;
    return mode_h[k % HR];
  endfunction

  task automatic chk(string tag, int actv, int expv);
    checks++;
    if (actv != expv) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, actv, expv);
    end
  endtask

  task automatic finish_frame();
    logic [8+N:0] e;
    bit m;
    logic [7:0] addr;
    logic [N-1:0] data;
    chk("R4 start bits", int'({fb[0], fb[1]}), 3);
    chk("R7 overflow bit", int'(fb[2]), int'(ovf_exp));
    if (exp_q.size() == 0) begin
      chk("R10 unexpected frame", 1, 0);
      return;
    end
    e = exp_q.pop_front();
    m = mode_q.pop_front();
    addr = '0;
    for (int i = 0; i < 8; i++) addr = {addr[6:0], fb[4+i]};
    for (int c = 0; c < N; c++) data[c] = fb[12+c];
    chk("R8 latency error bit", int'(fb[3]), int'(e[8+N]));
    chk("R5 address field", int'(addr), int'(e[N +: 8]));
    chk(e[8+N] ? "R8 cleared channels" : (m ? "R2 R3 edge data" : "R1 R3 level data"),
        int'(data), int'(e[N-1:0]));
  endtask

  task automatic parse(logic b);
    if (!in_frame) begin
      if (b) begin
        in_frame = 1; pos = 1; fb[0] = 1'b1;
        if (edge_n == last_end + 1) btb_n++;
        ovf_exp = 0;
        while (drop_q.size() > 0 && drop_q[0] < edge_n) begin
          void'(drop_q.pop_front());
          ovf_exp = 1;
        end
      end
    end else begin
      fb[pos] = b;
      pos++;
      if (pos == L) begin
        in_frame = 0;
        last_end = edge_n;
        finish_frame();
      end
    end
  endtask

  task automatic step(logic [N-1:0] nc, logic nt, logic nm, logic [7:0] nl, logic nf);
    bit fs;
    int e, fill, src;
    bit err;
    logic [N-1:0] d;
    fs = full;
    comp = nc; trig = nt; mode = nm; lat = nl; fast_rst = nf;
    @(posedge clk);
    edge_n++;
    det_h[edge_n % HR]  = nm ? (nc & ~prev_comp) : nc;
    mode_h[edge_n % HR] = nm;
    prev_comp = nc;
    if (nf) begin
      base = edge_n + 1;
      exp_q.delete(); mode_q.delete(); drop_q.delete();
    end else if (nt) begin
      if (fs) begin
        drop_q.push_back(edge_n);
        dropped_n++;
      end else begin
        e = edge_n - base;
        fill = (e > 256) ? 256 : e;
        err = (nl == 0) || (fill < int'(nl));
        src = edge_n - int'(nl);
        d = err ? '0 : det_at(src - 1);
        exp_q.push_back({err, 8'((e - int'(nl)) & 255), d});
        mode_q.push_back(mode_at(src - 1));
        accepted_n++;
      end
    end
    @(negedge clk);
    if (nf) begin
      in_frame = 0;
      last_end = -10;
    end
    parse(sdat);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(comp, 1'b0, mode, lat, 1'b0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog act=0 exp=1");
    summary();
    $finish;
  end

  initial begin : main
    int r, bt0, acc0, dr0;
    logic [7:0] cur_lat;
    logic cur_mode;
    void'($urandom(32'h1c0ffee));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R11 reset state
    chk("R11 sdat reset", int'(sdat), 0);
    chk("R11 count reset", int'(cnt), 0);
    chk("R11 full reset", int'(full), 0);
    chk("R11 active reset", int'(act), 0);

    // R8 trigger before enough samples exist
    for (int i = 0; i < 3; i++) step(16'h00ff, 1'b0, 1'b0, 8'd10, 1'b0);
    step(16'h00ff, 1'b1, 1'b0, 8'd10, 1'b0);
    idle(40);
    // R8 zero latency
    step(16'h1234, 1'b1, 1'b0, 8'd0, 1'b0);
    idle(35);

    // R1 level mode, varied pattern
    for (int i = 0; i < 20; i++) step(N'($urandom), 1'b0, 1'b0, 8'd5, 1'b0);
    step(16'ha5a5, 1'b1, 1'b0, 8'd5, 1'b0);
    idle(35);

    // R2 edge mode: held-high plateau and the rising edge itself
    for (int i = 0; i < 3; i++) step('0, 1'b0, 1'b1, 8'd5, 1'b0);
    step(16'hffff, 1'b0, 1'b1, 8'd5, 1'b0);
    r = edge_n;
    for (int i = 0; i < 7; i++) step(16'hffff, 1'b0, 1'b1, 8'd5, 1'b0);
    step(16'hffff, 1'b1, 1'b1, 8'd4, 1'b0);
    step(16'hffff, 1'b1, 1'b1, 8'(edge_n + 1 - 1 - r), 1'b0);
    idle(70);

    // R3 maximum latency after the pipeline has wrapped
    while (edge_n < 320) step(N'($urandom), 1'b0, 1'b0, 8'd255, 1'b0);
    step(N'($urandom), 1'b1, 1'b0, 8'd255, 1'b0);
    idle(40);

    // R6 R7 R10 burst longer than the buffer
    bt0 = btb_n; acc0 = accepted_n; dr0 = dropped_n;
    for (int i = 0; i < 45; i++) step(N'($urandom), 1'b1, 1'b0, 8'd20, 1'b0);
    chk("R6 buffer count at full", int'(cnt), 32);
    chk("R6 full flag", int'(full), 1);
    chk("R6 triggers dropped", int'(dropped_n > dr0), 1);
    idle(40 * L);
    chk("R10 all burst frames sent", exp_q.size(), 0);
    chk("R10 back-to-back frames", btb_n - bt0, accepted_n - acc0 - 1);

    // R9 fast reset with a full buffer, a pending overflow and a frame in flight
    for (int i = 0; i < 45; i++) step(N'($urandom), 1'b1, 1'b0, 8'd20, 1'b0);
    step(comp, 1'b1, 1'b0, 8'd3, 1'b1);
    chk("R9 line idle after fast reset", int'(sdat), 0);
    chk("R9 buffer empty after fast reset", int'(cnt), 0);
    chk("R9 no frame active", int'(act), 0);
    step(16'h0f0f, 1'b0, 1'b0, 8'd3, 1'b0);
    step(16'h0f0f, 1'b1, 1'b0, 8'd3, 1'b0);
    for (int i = 0; i < 5; i++) step(N'($urandom), 1'b0, 1'b0, 8'd3, 1'b0);
    step(16'h3c3c, 1'b1, 1'b0, 8'd3, 1'b0);
    idle(80);
    chk("R9 frames after fast reset", exp_q.size(), 0);

    // random traffic
    cur_lat = 8'd40; cur_mode = 1'b0;
    for (int i = 0; i < 15000; i++) begin
      if ($urandom % 600 == 0) cur_mode = ~cur_mode;
      if ($urandom % 2500 == 0) cur_lat = 8'($urandom % 256);
      step(N'($urandom), ($urandom % 40) == 0, cur_mode, cur_lat, 1'b0);
    end
    for (int i = 0; i < 2000 && (exp_q.size() > 0 || in_frame); i++) idle(1);
    chk("R10 random traffic drained", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule